// File: doc/BRIEF.md
# Single-Request Interrupt Concentrator

This block gathers sixty-four level-sensitive interrupt lines and presents at most one of them to the processor as a request. The request is a one-hot vector whose set bit is the source number. Lines 0 to 31 come from expansion-bus slots and lines 32 to 63 come from on-board peripherals. Software enables each line through a mapping register. Each on-board line has its own mapping register. The slot lines share one mapping register per group of four.

A request stays up until software retires it. Software can do this with a clear write or by disabling the request's mapping. The block then rescans the active, enabled lines and forwards the lowest-numbered one. A newly rising slot line that is enabled takes over from any outstanding request. A newly rising on-board line only starts a request when nothing is outstanding.

Register access uses a 16-bit byte address with a single-cycle write strobe. Reads are combinational. Only the upper word of each eight-byte pair acts (address bit 2 set). The lower word reads as zero.

| Window | Range | Stride | Index |
|---|---|---|---|
| Slot mapping | 0x0C00 to 0x0C3F | 8 | group = addr[5:3] |
| On-board mapping | 0x1000 to 0x10FF | 8 | source − 32 = addr[7:3] |
| Slot clear | 0x1400 to 0x14FF | 32 | group = addr[7:5] |
| On-board clear | 0x1800 to 0x18FF | 8 | source − 32 = addr[7:3] |

Top module: `irq_concentrator`

## Requirements
- R1: While `rst` is high at a clock edge, the request output clears to zero, every mapping enable (bit 31) clears, and every latched input level clears.
- R2: A mapping write changes only bit 31. Reading the mapping register back gives the enable bit in bit 31. Bits 30:0 are fixed: 0x7C0 + 4*group for slot register `group`, and 0x7E0 + k for on-board register k. A write or read of the lower word (address bit 2 clear) of any window has no effect and reads 0.
- R3: Slot mapping register g enables sources 4g to 4g+3. On-board mapping register k enables source 32+k.
- R4: Requests are registered and appear one clock after the triggering write or input edge. A request is only ever forwarded for a source whose enable is set. A line whose enable is clear produces no request.
- R5: At most one output bit is ever set. An enabled slot line that rises replaces any outstanding request. An enabled on-board line that rises while a request is outstanding is ignored.
- R6: Without a bus write, an outstanding request stays asserted, even after its input line falls.
- R7: A rescan keeps an outstanding request. Otherwise it selects the lowest-numbered source whose line is high and whose enable is set, so slot lines win over on-board lines.
- R8: A mapping write with bit 31 clear drops the outstanding request if that register covers the request's source. Disabling a register that does not cover the request leaves the request in place.
- R9: A slot clear for group g drops the request if the request index divided by four equals g, and then rescans. Any other group has no effect.
- R10: An on-board clear at index k drops the request only if the request index equals 32+k, and then rescans.
- R11: Every mapping write triggers a rescan. Enabling a register while no request is outstanding and a covered line is high raises that request.
- R12: Addresses outside the four windows read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_lvl | input | 64 | Interrupt line levels, bit n is source n |
| req_o | output | 64 | One-hot request, bit n means source n is requested |

## Verification
The bench targets four kinds of corner case.

- **Group match on slot clears.** A slot clear aimed at the wrong group must leave the request alone. A design that compares the full index would miss a valid clear. One that ignores the group would drop the request wrongly.
- **Preemption asymmetry.** A rising slot line must displace the current request, while a rising on-board line must not. A design that treats both the same shows the wrong index.
- **Held requests.** A request must survive its input line falling. A design that tracks levels drops it early.
- **Address handling.** Disabling a neighbouring register, lower-word accesses and out-of-window writes must all leave the output untouched. Readback must show that only bit 31 of a mapping register changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC   = 64;
    localparam int SLOT_SRC  = 32;
    localparam int GRP_SIZE  = 4;
    localparam int SLOT_REGS = SLOT_SRC / GRP_SIZE;
    localparam int OB_REGS   = NUM_SRC - SLOT_SRC;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int OB_W      = $clog2(OB_REGS);
    localparam int GRP_W     = $clog2(SLOT_REGS);
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MAP_SLOT,
        OP_MAP_OB,
        OP_CLR_SLOT,
        OP_CLR_OB
    } bus_op_e;

    typedef struct packed {
        bus_op_e         op;
        logic [OB_W-1:0] idx;
    } bus_evt_t;

    function automatic bus_evt_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_evt_t e;
        e.op  = OP_NONE;
        e.idx = '0;
        if (a[2]) begin
            if (a[15:6] == 10'h030) begin
                e.op  = OP_MAP_SLOT;
                e.idx = OB_W'(a[5:3]);
            end else if (a[15:8] == 8'h10) begin
                e.op  = OP_MAP_OB;
                e.idx = a[7:3];
            end else if (a[15:8] == 8'h14) begin
                e.op  = OP_CLR_SLOT;
                e.idx = OB_W'(a[7:5]);
            end else if (a[15:8] == 8'h18) begin
                e.op  = OP_CLR_OB;
                e.idx = a[7:3];
            end
        end
        return e;
    endfunction

    function automatic logic [30:0] slot_fixed(input logic [GRP_W-1:0] g);
        return 31'(12'h7C0 | {7'd0, g, 2'b00});
    endfunction

    function automatic logic [30:0] ob_fixed(input logic [OB_W-1:0] k);
        return 31'(12'h7E0 + {7'd0, k});
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output bus_evt_t          evt
);
    always_comb evt = decode_addr(addr);
endmodule

// File: rtl/irqc_first.sv
module irqc_first #(
    parameter int W   = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_mapregs.sv
module irqc_mapregs
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               wbit,
    input  bus_evt_t           evt,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] en_nx
);
    logic [SLOT_REGS-1:0] slot_v, slot_nx;
    logic [OB_REGS-1:0]   ob_v, ob_nx;

    always_comb begin
        slot_nx = slot_v;
        ob_nx   = ob_v;
        if (wr && evt.op == OP_MAP_SLOT) slot_nx[evt.idx[GRP_W-1:0]] = wbit;
        if (wr && evt.op == OP_MAP_OB)   ob_nx[evt.idx] = wbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= '0;
            ob_v   <= '0;
        end else begin
            slot_v <= slot_nx;
            ob_v   <= ob_nx;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        if (i < SLOT_SRC) begin : g_slot
            assign en_nx[i] = slot_nx[i / GRP_SIZE];
            assign en_q[i]  = slot_v[i / GRP_SIZE];
        end else begin : g_ob
            assign en_nx[i] = ob_nx[i - SLOT_SRC];
            assign en_q[i]  = ob_v[i - SLOT_SRC];
        end
    end

    always_comb begin
        unique case (evt.op)
            OP_MAP_SLOT: rdata = {slot_v[evt.idx[GRP_W-1:0]], slot_fixed(evt.idx[GRP_W-1:0])};
            OP_MAP_OB:   rdata = {ob_v[evt.idx], ob_fixed(evt.idx)};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lvl,
    output logic [NUM_SRC-1:0] req_o
);
    bus_evt_t           evt;
    logic [NUM_SRC-1:0] en_q, en_nx, lvl_q, req_q;
    logic               pend_v, pend_v_n;
    logic [IDX_W-1:0]   pend_i, pend_i_n;

    logic               scan_any, rs_any, ro_any;
    logic [IDX_W-1:0]   scan_idx;
    logic [OB_W-1:0]    rs_idx, ro_idx;
    logic [NUM_SRC-1:0] rise;

    irqc_decode u_dec (.addr(bus_addr), .evt(evt));

    irqc_mapregs u_map (
        .clk(clk), .rst(rst), .wr(bus_wr), .wbit(bus_wdata[DATA_W-1]),
        .evt(evt), .rdata(bus_rdata), .en_q(en_q), .en_nx(en_nx)
    );

    assign rise = irq_lvl & ~lvl_q & en_nx;

    irqc_first #(.W(NUM_SRC)) u_scan (
        .vec(irq_lvl & en_nx), .any(scan_any), .idx(scan_idx));
    irqc_first #(.W(SLOT_SRC)) u_rslot (
        .vec(rise[SLOT_SRC-1:0]), .any(rs_any), .idx(rs_idx));
    irqc_first #(.W(OB_REGS)) u_rob (
        .vec(rise[NUM_SRC-1:SLOT_SRC]), .any(ro_any), .idx(ro_idx));

    always_comb begin
        logic drop, rescan;
        drop   = 1'b0;
        rescan = 1'b0;
        if (bus_wr) begin
            case (evt.op)
                OP_MAP_SLOT: begin
                    rescan = 1'b1;
                    drop   = !bus_wdata[DATA_W-1] && pend_v &&
                             pend_i[IDX_W-1:2] == {1'b0, evt.idx[GRP_W-1:0]};
                end
                OP_MAP_OB: begin
                    rescan = 1'b1;
                    drop   = !bus_wdata[DATA_W-1] && pend_v && pend_i == {1'b1, evt.idx};
                end
                OP_CLR_SLOT: begin
                    drop   = pend_v && pend_i[IDX_W-1:2] == {1'b0, evt.idx[GRP_W-1:0]};
                    rescan = drop;
                end
                OP_CLR_OB: begin
                    drop   = pend_v && pend_i == {1'b1, evt.idx};
                    rescan = drop;
                end
                default: ;
            endcase
        end
        pend_v_n = pend_v & ~drop;
        pend_i_n = pend_i;
        if (rescan && !pend_v_n) begin
            pend_v_n = scan_any;
            pend_i_n = scan_idx;
        end
        if (rs_any) begin
            pend_v_n = 1'b1;
            pend_i_n = {1'b0, rs_idx};
        end else if (!pend_v_n && ro_any) begin
            pend_v_n = 1'b1;
            pend_i_n = {1'b1, ro_idx};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_i <= '0;
            lvl_q  <= '0;
            req_q  <= '0;
        end else begin
            pend_v <= pend_v_n;
            pend_i <= pend_i_n;
            lvl_q  <= irq_lvl;
            req_q  <= pend_v_n ? (NUM_SRC'(1) << pend_i_n) : '0;
        end
    end

    assign req_o = req_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> req_q == '0);
    // R5
    one_req_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(req_q));
    // R4
    enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q & ~en_q) == '0);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q != '0 && !bus_wr) |=> req_q != '0);
    // R5
    ob_no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q != '0 && !bus_wr) |=>
        (req_q == $past(req_q) || req_q[NUM_SRC-1:SLOT_SRC] == '0));
endmodule

// File: tb/irq_concentrator_bench.sv
module irq_concentrator_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_lvl = '0;
    logic [63:0] req_o;

    int runs = 0, fails = 0;

    always #4 clk = ~clk;

    irq_concentrator u_irq_concentrator (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lvl(irq_lvl), .req_o(req_o));

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [63:0] lvl;
        logic [6:0]  exp;
        logic [3:0]  rq;
    } vec_t;

    localparam logic [6:0]  NONE = 7'd64;
    localparam logic [31:0] EN   = 32'h8000_0000;
    localparam logic [63:0] B1 = 64'd1 << 1, B4 = 64'd1 << 4, B5 = 64'd1 << 5,
                            B6 = 64'd1 << 6, B33 = 64'd1 << 33, B40 = 64'd1 << 40;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h0000, 32'h0,  64'h0,     NONE,  4'd1},  // R1 idle after reset
        '{1'b0, 16'h0000, 32'h0,  B5,        NONE,  4'd4},  // R4 disabled line
        '{1'b1, 16'h0C0C, EN,     B5,        7'd5,  4'd11}, // R11 R3 enable group 1
        '{1'b0, 16'h0000, 32'h0,  64'h0,     7'd5,  4'd6},  // R6 line fell
        '{1'b1, 16'h1044, EN,     B40,       7'd5,  4'd5},  // R5 on-board rise ignored
        '{1'b0, 16'h0000, 32'h0,  B40 | B6,  7'd6,  4'd5},  // R5 slot rise preempts
        '{1'b1, 16'h1404, 32'h0,  B40 | B6,  7'd6,  4'd9},  // R9 wrong group
        '{1'b1, 16'h1424, 32'h0,  B40,       7'd40, 4'd9},  // R9 R7 clear, rescan
        '{1'b1, 16'h183C, 32'h0,  B40,       7'd40, 4'd10}, // R10 mismatch
        '{1'b1, 16'h100C, EN,     B40 | B33, 7'd40, 4'd5},  // R5 pending kept
        '{1'b1, 16'h1844, 32'h0,  B40 | B33, 7'd33, 4'd7},  // R7 R10 lowest wins
        '{1'b1, 16'h100C, 32'h0,  B40 | B33, 7'd40, 4'd8},  // R8 disable own
        '{1'b1, 16'h0C04, 32'h0,  B40 | B33, 7'd40, 4'd8},  // R8 disable other
        '{1'b0, 16'h0000, 32'h0,  B40 | B4,  7'd4,  4'd5},  // R5 slot preempts
        '{1'b1, 16'h0C0C, 32'h0,  B40 | B4,  7'd40, 4'd3},  // R3 R8 group disable
        '{1'b1, 16'h0C04, EN,     B40 | B1,  7'd1,  4'd5},  // R5 enable+rise
        '{1'b1, 16'h1404, 32'h0,  B40,       7'd40, 4'd9},  // R9 group 0
        '{1'b1, 16'h1840, 32'h0,  64'h0,     7'd40, 4'd2},  // R2 lower word
        '{1'b1, 16'h2000, 32'h0,  64'h0,     7'd40, 4'd12}, // R12 unmapped write
        '{1'b1, 16'h1844, 32'h0,  64'h0,     NONE,  4'd10}  // R10 drop to none
    };

    task automatic check_req(input logic [6:0] e, input int rq);
        logic [63:0] x;
        x = (e == NONE) ? 64'h0 : (64'd1 << e);
        runs++;
        if (req_o !== x) begin
            fails++;
            $display("FAIL R%0d req actual=%h expected=%h", rq, req_o, x);
        end
    endtask

    task automatic check_rd(input logic [15:0] a, input logic [31:0] x, input int rq);
        bus_addr = a;
        bus_wr = 0;
        #1;
        runs++;
        if (bus_rdata !== x) begin
            fails++;
            $display("FAIL R%0d read %h actual=%h expected=%h", rq, a, bus_rdata, x);
        end
    endtask

    task automatic step(input logic w, input logic [15:0] a, input logic [31:0] d,
                        input logic [63:0] l);
        bus_wr = w; bus_addr = a; bus_wdata = d; irq_lvl = l;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check_req(NONE, 1);
        check_rd(16'h0C0C, 32'h0000_07C4, 1);
        // R2 on-board power-up readback
        check_rd(16'h103C, 32'h0000_07E7, 2);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].lvl);
            check_req(TBL[i].exp, int'(TBL[i].rq));
        end

        // R2 readback shows enable plus fixed field
        check_rd(16'h0C04, 32'h8000_07C0, 2);
        check_rd(16'h0C0C, 32'h0000_07C4, 3);
        check_rd(16'h1044, 32'h8000_07E8, 2);
        check_rd(16'h0C00, 32'h0, 2);
        // R12 unmapped read
        check_rd(16'h2000, 32'h0, 12);
        // R2 only bit 31 written
        step(1'b1, 16'h0C04, 32'h7FFF_FFFF, 64'h0);
        check_rd(16'h0C04, 32'h0000_07C0, 2);
        step(1'b1, 16'h101C, 32'hFFFF_FFFF, 64'h0);
        check_rd(16'h101C, 32'h8000_07E3, 2);
        // R12 write to an unmapped address between windows
        step(1'b1, 16'h0C44, EN, 64'h0);
        check_rd(16'h0C44, 32'h0, 12);
        // R4 enabled on-board rise after idle
        step(1'b0, 16'h0000, 32'h0, 64'd1 << 35);
        check_req(7'd35, 4);
        // R1 reset clears request and enables
        rst = 1;
        step(1'b0, 16'h0000, 32'h0, 64'd1 << 35);
        rst = 0;
        check_req(NONE, 1);
        check_rd(16'h101C, 32'h0000_07E3, 1);
        step(1'b0, 16'h0000, 32'h0, 64'd1 << 35);
        check_req(NONE, 1);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule